// File: doc/BRIEF.md
# Synthesizer Control Register Interface

This block is a two-wire (I2C fast-mode) slave that holds the programming registers of a frequency synthesizer. It answers to a seven-bit device address. The upper five bits of that address are fixed. The next two bits come from strap pins, so four synthesizers can share one bus. The read/write bit follows as the LSB.

In a write transfer the slave steers data bytes into a 15-bit main divider word and a group of control fields: operating mode, reference-divider select and charge-pump current select. The most significant bit of the first data byte decides where the write starts. Writes then auto-increment through the register sequence until the transfer ends. The divider word is applied as a coherent whole: after its second byte, or at STOP if only its first byte was sent.

In a read transfer the slave returns a status byte that carries a power-on flag and a lock flag. The power-on flag is set by reset or by a supply-low indication. It is cleared when the master ends a read with a NACK.

The SCL and SDA lines are sampled on a system clock at least sixteen times faster than SCL. SDA is driven through an open-drain enable.

Top module: `synth_i2c_ctrl`

## Requirements
- R1: After reset, mode_sel is 001, div_ratio, ref_sel and cp_sel are zero, sda_oe is 0, and the power-on flag is 1.
- R2: The slave acknowledges only an address byte of the form 1 1 0 0 0, strap_ma[1], strap_ma[0], R/W (R/W is the LSB, and 1 means read). Any other address gets no acknowledge, and the bytes that follow it change no register.
- R3: In the first data byte of a write, MSB 0 selects the first divider byte and MSB 1 selects the first control byte. Later bytes then advance through the order: divider byte 1, divider byte 2, control byte 1, control byte 2.
- R4: Bits [6:0] of divider byte 1 form div_ratio[14:8], and divider byte 2 forms div_ratio[7:0]. div_ratio does not change after divider byte 1. It takes both halves together at the eighth SCL rise of divider byte 2.
- R5: If a transfer writes divider byte 1 but not divider byte 2, div_ratio[14:8] takes the new bits at STOP, and div_ratio[7:0] keeps its value.
- R6: Control byte 1 bits [6:4] drive mode_sel and bits [3:1] drive ref_sel. Control byte 2 bits [7:6] drive cp_sel. Each field applies at the eighth SCL rise of its own byte.
- R7: Data bytes written after control byte 2 in the same transfer are acknowledged and change no output.
- R8: A read returns a status byte MSB first: bit 7 is the power-on flag, bit 6 is lock_i, and bits 5..0 are zero.
- R9: A master ACK after a status byte makes the slave send the same status byte again. A master NACK releases SDA and clears the power-on flag.
- R10: A one-cycle pulse on supply_low sets the power-on flag and returns mode_sel to 001.
- R11: A START or STOP, at any bit position, abandons the current byte and releases SDA. A repeated START begins a new address phase and does not apply a pending divider byte 1; that byte is applied only at the STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst | input | 1 | Synchronous active-high power-on reset |
| supply_low | input | 1 | Supply-low indication; sets the power-on flag and the default mode |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| strap_ma | input | 2 | Address strap bits |
| lock_i | input | 1 | Synthesizer lock indication, reported in the status byte |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| div_ratio | output | 15 | Applied main divider ratio |
| mode_sel | output | 3 | Applied operating mode |
| ref_sel | output | 3 | Applied reference divider select |
| cp_sel | output | 2 | Applied charge-pump current select |

## Verification
The bench checks div_ratio between the two divider bytes and again before STOP. A design that applied each byte as it arrived would show a half-updated ratio there. A design that ignored STOP would never apply a lone first byte.

The bench also starts a write at the first control byte and writes past the last register. A wrong first-bit decode, or a pointer that wraps, would corrupt the divider.

Reads are checked three ways. Two status bytes are read back to back, the power-on flag is checked to fall only after a NACK, and a repeated START is sent with a pending divider byte. A design that cleared the flag on each byte, or applied the pending byte at the restart, would fail these checks.

// File: rtl/synth_i2c_pkg.sv
package synth_i2c_pkg;

    localparam int DIV_W    = 15;
    localparam int MODE_W   = 3;
    localparam int REF_W    = 3;
    localparam int CP_W     = 2;
    localparam int BYTE_W   = 8;
    localparam int HI_W     = DIV_W - BYTE_W;
    localparam int CNT_W    = $clog2(BYTE_W + 1);

    localparam logic [4:0]        ADDR_FIXED = 5'b11000;
    localparam logic [MODE_W-1:0] MODE_POR   = 3'b001;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_RNEXT,
        ST_IGN
    } bus_state_t;

    typedef enum logic [2:0] {
        TGT_PD_HI,
        TGT_PD_LO,
        TGT_CTL_A,
        TGT_CTL_B,
        TGT_NONE
    } target_t;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [REF_W-1:0]  refsel;
        logic [CP_W-1:0]   cp;
    } ctrl_t;

    function automatic logic addr_hit(input logic [6:0] a, input logic [1:0] strap);
        return a == {ADDR_FIXED, strap};
    endfunction

    function automatic logic [BYTE_W-1:0] status_word(input logic por, input logic lock);
        return {por, lock, {(BYTE_W-2){1'b0}}};
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_val,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_now;
    logic              sda_now;

    assign scl_now = scl_ff[STAGES-1];
    assign sda_now = sda_ff[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff   <= '1;
            sda_ff   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_ff   <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff   <= {sda_ff[STAGES-2:0], sda_i};
            scl_prev <= scl_now;
            sda_prev <= sda_now;
        end
    end

    assign scl_rise  = scl_now & ~scl_prev;
    assign scl_fall  = ~scl_now & scl_prev;
    assign sda_val   = sda_now;
    assign start_evt = scl_now & scl_prev & sda_prev & ~sda_now;
    assign stop_evt  = scl_now & scl_prev & ~sda_prev & sda_now;

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import synth_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_val,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [1:0]        strap,
    input  logic [BYTE_W-1:0] status,
    output logic              sda_oe,
    output logic              wr_valid,
    output logic              wr_first,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              rd_done
);
    bus_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] tx;
    logic              rw;
    logic              first;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            tx       <= '0;
            rw       <= 1'b0;
            first    <= 1'b0;
            sda_oe   <= 1'b0;
            wr_valid <= 1'b0;
            wr_first <= 1'b0;
            wr_byte  <= '0;
            rd_done  <= 1'b0;
        end else begin
            wr_valid <= 1'b0;
            rd_done  <= 1'b0;
            if (start_evt) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_evt) begin
                state  <= ST_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_val};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
                            cnt <= '0;
                            if (addr_hit(shreg[BYTE_W-1:1], strap)) begin
                                rw     <= shreg[0];
                                sda_oe <= 1'b1;
                                state  <= ST_AACK;
                            end else begin
                                state <= ST_IGN;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                tx     <= status;
                                sda_oe <= ~status[BYTE_W-1];
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                first  <= 1'b1;
                                state  <= ST_WDATA;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_val};
                            cnt   <= cnt + 1'b1;
                            if (cnt == CNT_W'(BYTE_W - 1)) begin
                                wr_valid <= 1'b1;
                                wr_first <= first;
                                wr_byte  <= {shreg[BYTE_W-2:0], sda_val};
                            end
                        end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
                            first  <= 1'b0;
                            sda_oe <= 1'b1;
                            cnt    <= '0;
                            state  <= ST_WACK;
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt == CNT_W'(BYTE_W)) begin
                                sda_oe <= 1'b0;
                                cnt    <= '0;
                                state  <= ST_RACK;
                            end else begin
                                tx     <= {tx[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx[BYTE_W-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            if (sda_val) begin
                                rd_done <= 1'b1;
                                state   <= ST_IGN;
                            end else begin
                                state <= ST_RNEXT;
                            end
                        end
                    end
                    ST_RNEXT: begin
                        if (scl_fall) begin
                            tx     <= status;
                            sda_oe <= ~status[BYTE_W-1];
                            cnt    <= '0;
                            state  <= ST_RDATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R11: bus conditions always free the data line
    p_stop_release_r11: assert property (@(posedge clk) disable iff (rst)
        (stop_evt || start_evt) |=> !sda_oe);

    // R9: after a master NACK the line is not held
    p_nack_release_r9: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> !sda_oe);

endmodule

// File: rtl/synth_reg_bank.sv
module synth_reg_bank
    import synth_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_low,
    input  logic              wr_valid,
    input  logic              wr_first,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              stop_evt,
    input  logic              rd_done,
    output logic [DIV_W-1:0]  div_ratio,
    output ctrl_t             ctrl_q,
    output logic              por_flag
);
    target_t         ptr;
    target_t         tgt;
    logic [HI_W-1:0] hi_hold;
    logic            hi_pend;

    always_comb begin
        if (wr_first) tgt = wr_byte[BYTE_W-1] ? TGT_CTL_A : TGT_PD_HI;
        else          tgt = ptr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr       <= TGT_NONE;
            hi_hold   <= '0;
            hi_pend   <= 1'b0;
            div_ratio <= '0;
            ctrl_q    <= '{mode: MODE_POR, refsel: '0, cp: '0};
            por_flag  <= 1'b1;
        end else begin
            if (wr_valid) begin
                case (tgt)
                    TGT_PD_HI: begin
                        hi_hold <= wr_byte[HI_W-1:0];
                        hi_pend <= 1'b1;
                        ptr     <= TGT_PD_LO;
                    end
                    TGT_PD_LO: begin
                        div_ratio <= {hi_hold, wr_byte};
                        hi_pend   <= 1'b0;
                        ptr       <= TGT_CTL_A;
                    end
                    TGT_CTL_A: begin
                        ctrl_q.mode   <= wr_byte[6:4];
                        ctrl_q.refsel <= wr_byte[3:1];
                        ptr           <= TGT_CTL_B;
                    end
                    TGT_CTL_B: begin
                        ctrl_q.cp <= wr_byte[7:6];
                        ptr       <= TGT_NONE;
                    end
                    default: ptr <= TGT_NONE;
                endcase
            end else if (stop_evt) begin
                ptr <= TGT_NONE;
                if (hi_pend) begin
                    div_ratio[DIV_W-1:BYTE_W] <= hi_hold;
                    hi_pend                   <= 1'b0;
                end
            end
            if (supply_low) begin
                ctrl_q.mode <= MODE_POR;
                por_flag    <= 1'b1;
            end else if (rd_done) begin
                por_flag <= 1'b0;
            end
        end
    end

    // R4: the divider moves only on a byte strobe or a STOP
    p_div_commit_only_r4: assert property (@(posedge clk) disable iff (rst)
        !(wr_valid || stop_evt) |=> $stable(div_ratio));

    // R6: control fields move only on a byte strobe or supply-low
    p_ctrl_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(wr_valid || supply_low) |=> $stable(ctrl_q));

    // R9: the end of a read clears the power-on flag
    p_por_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_done && !supply_low) |=> !por_flag);

    // R10: supply-low restores the power-on state
    p_supply_low_r10: assert property (@(posedge clk) disable iff (rst)
        supply_low |=> (por_flag && ctrl_q.mode == MODE_POR));

endmodule

// File: rtl/synth_i2c_ctrl.sv
module synth_i2c_ctrl
    import synth_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_low,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        strap_ma,
    input  logic              lock_i,
    output logic              sda_oe,
    output logic [DIV_W-1:0]  div_ratio,
    output logic [MODE_W-1:0] mode_sel,
    output logic [REF_W-1:0]  ref_sel,
    output logic [CP_W-1:0]   cp_sel
);
    logic              scl_rise;
    logic              scl_fall;
    logic              sda_val;
    logic              start_evt;
    logic              stop_evt;
    logic              wr_valid;
    logic              wr_first;
    logic [BYTE_W-1:0] wr_byte;
    logic              rd_done;
    logic              por_flag;
    ctrl_t             ctrl_q;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_val   (sda_val),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2c_slave_fsm fsm_i (
        .clk       (clk),
        .rst       (rst),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_val   (sda_val),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .strap     (strap_ma),
        .status    (status_word(por_flag, lock_i)),
        .sda_oe    (sda_oe),
        .wr_valid  (wr_valid),
        .wr_first  (wr_first),
        .wr_byte   (wr_byte),
        .rd_done   (rd_done)
    );

    synth_reg_bank regs_i (
        .clk        (clk),
        .rst        (rst),
        .supply_low (supply_low),
        .wr_valid   (wr_valid),
        .wr_first   (wr_first),
        .wr_byte    (wr_byte),
        .stop_evt   (stop_evt),
        .rd_done    (rd_done),
        .div_ratio  (div_ratio),
        .ctrl_q     (ctrl_q),
        .por_flag   (por_flag)
    );

    assign mode_sel = ctrl_q.mode;
    assign ref_sel  = ctrl_q.refsel;
    assign cp_sel   = ctrl_q.cp;

endmodule

// File: tb/synth_i2c_ctrl_tb_top.sv
module synth_i2c_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        supply_low = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  strap_ma = 2'b10;
    logic        lock_i = 1'b1;
    logic        sda_oe;
    logic        sda_bus;
    logic [14:0] div_ratio;
    logic [2:0]  mode_sel;
    logic [2:0]  ref_sel;
    logic [1:0]  cp_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [7:0] A_WR  = 8'hC4;
    localparam logic [7:0] A_RD  = 8'hC5;
    localparam logic [7:0] A_BAD = 8'hC2;

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    synth_i2c_ctrl dut_i (
        .clk        (clk),
        .rst        (rst),
        .supply_low (supply_low),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .strap_ma   (strap_ma),
        .lock_i     (lock_i),
        .sda_oe     (sda_oe),
        .div_ratio  (div_ratio),
        .mode_sel   (mode_sel),
        .ref_sel    (ref_sel),
        .cp_sel     (cp_sel)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic i2c_start();
        sda_m = 1'b0; wait_clk(20);
        scl_m = 1'b0;
    endtask

    task automatic i2c_restart();
        wait_clk(5);  sda_m = 1'b1;
        wait_clk(15); scl_m = 1'b1;
        wait_clk(20); sda_m = 1'b0;
        wait_clk(20); scl_m = 1'b0;
    endtask

    task automatic i2c_stop();
        wait_clk(5);  sda_m = 1'b0;
        wait_clk(15); scl_m = 1'b1;
        wait_clk(20); sda_m = 1'b1;
        wait_clk(20);
    endtask

    task automatic clock_bit(input logic b, output logic s);
        wait_clk(5);  sda_m = b;
        wait_clk(15); scl_m = 1'b1;
        wait_clk(10); s = sda_bus;
        wait_clk(10); scl_m = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, ack);
    endtask

    task automatic rbyte(input logic master_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            b[i] = s;
        end
        clock_bit(~master_ack, s);
        wait_clk(5); sda_m = 1'b1;
    endtask

    task automatic t_reset();
        check("R1 mode", 32'(mode_sel), 32'd1);
        check("R1 div", 32'(div_ratio), 32'd0);
        check("R1 ref/cp", {27'd0, ref_sel, cp_sel}, 32'd0);
        check("R1 sda_oe", 32'(sda_oe), 32'd0);
    endtask

    task automatic t_read_status();
        logic a;
        logic [7:0] b;
        lock_i = 1'b1;
        i2c_start();
        wbyte(A_RD, a);
        check("R2 read address ack", 32'(a), 32'd0);
        rbyte(1'b1, b);
        check("R1 R8 status por/lock", 32'(b[7:6]), 32'd3);
        check("R8 status low bits", 32'(b[5:0]), 32'd0);
        rbyte(1'b0, b);
        check("R9 repeat status", 32'(b[7:6]), 32'd3);
        wait_clk(10);
        check("R9 released after nack", 32'(sda_oe), 32'd0);
        i2c_stop();
        i2c_start();
        wbyte(A_RD, a);
        rbyte(1'b0, b);
        i2c_stop();
        check("R9 por cleared", 32'(b[7:6]), 32'd1);
        lock_i = 1'b0;
        i2c_start();
        wbyte(A_RD, a);
        rbyte(1'b0, b);
        i2c_stop();
        check("R8 lock low", 32'(b[7:6]), 32'd0);
    endtask

    task automatic t_bad_addr();
        logic a;
        i2c_start();
        wbyte(A_BAD, a);
        check("R2 wrong address nack", 32'(a), 32'd1);
        wbyte(8'hF0, a);
        check("R2 data after wrong address nack", 32'(a), 32'd1);
        i2c_stop();
        check("R2 mode untouched", 32'(mode_sel), 32'd1);
    endtask

    task automatic t_full_write();
        logic a;
        i2c_start();
        wbyte(A_WR, a);
        check("R2 write address ack", 32'(a), 32'd0);
        wbyte(8'h2A, a);
        check("R4 div held after first byte", 32'(div_ratio), 32'd0);
        wbyte(8'h5C, a);
        check("R4 div applied", 32'(div_ratio), 32'h2A5C);
        wbyte(8'hD4, a);
        check("R3 R6 mode", 32'(mode_sel), 32'd5);
        check("R6 ref", 32'(ref_sel), 32'd2);
        wbyte(8'hC0, a);
        check("R6 cp", 32'(cp_sel), 32'd3);
        wbyte(8'h3F, a);
        check("R7 extra byte ack", 32'(a), 32'd0);
        check("R7 extra byte ignored", {div_ratio, 7'd0, mode_sel, ref_sel, cp_sel},
              {15'h2A5C, 7'd0, 3'd5, 3'd2, 2'd3});
        i2c_stop();
        check("R4 div after stop", 32'(div_ratio), 32'h2A5C);
    endtask

    task automatic t_pd_only();
        logic a;
        i2c_start();
        wbyte(A_WR, a);
        wbyte(8'h11, a);
        check("R5 div before stop", 32'(div_ratio), 32'h2A5C);
        i2c_stop();
        check("R5 div at stop", 32'(div_ratio), 32'h115C);
    endtask

    task automatic t_ctl_start();
        logic a;
        i2c_start();
        wbyte(A_WR, a);
        wbyte(8'hCE, a);
        check("R3 start at control mode", 32'(mode_sel), 32'd4);
        check("R3 start at control ref", 32'(ref_sel), 32'd7);
        check("R3 divider untouched", 32'(div_ratio), 32'h115C);
        wbyte(8'h40, a);
        check("R3 cp next", 32'(cp_sel), 32'd1);
        wbyte(8'h00, a);
        check("R7 no wrap ack", 32'(a), 32'd0);
        i2c_stop();
        check("R7 no wrap to divider", 32'(div_ratio), 32'h115C);
    endtask

    task automatic t_restart();
        logic a;
        i2c_start();
        wbyte(A_WR, a);
        wbyte(8'h03, a);
        i2c_restart();
        wbyte(A_WR, a);
        check("R11 readdress ack", 32'(a), 32'd0);
        wbyte(8'h9A, a);
        check("R11 mode after restart", 32'(mode_sel), 32'd1);
        check("R11 ref after restart", 32'(ref_sel), 32'd5);
        check("R11 pending held", 32'(div_ratio), 32'h115C);
        i2c_stop();
        check("R11 pending at stop", 32'(div_ratio), 32'h035C);
    endtask

    task automatic t_supply_low();
        logic a;
        logic [7:0] b;
        i2c_start();
        wbyte(A_WR, a);
        wbyte(8'hF0, a);
        i2c_stop();
        check("R10 mode set first", 32'(mode_sel), 32'd7);
        supply_low = 1'b1; wait_clk(1);
        supply_low = 1'b0; wait_clk(2);
        check("R10 mode restored", 32'(mode_sel), 32'd1);
        lock_i = 1'b1;
        i2c_start();
        wbyte(A_RD, a);
        rbyte(1'b0, b);
        i2c_stop();
        check("R10 por set", 32'(b[7:6]), 32'd3);
    endtask

    initial begin
        wait_clk(4);
        rst = 1'b0;
        wait_clk(4);
        t_reset();
        t_read_status();
        t_bad_addr();
        t_full_write();
        t_pd_only();
        t_ctl_start();
        t_restart();
        t_supply_low();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule